// File: doc/BRIEF.md
# Timed Configuration-Byte Readback Window

This block sits beside a small processor core, between its program-memory load path and the nonvolatile configuration storage. Software writes a three-bit control register to arm one of two readback modes: configuration read or signature read. Arming opens a short window counted in processor cycles. A program-memory load that falls inside the window does not return program memory. It returns a configuration byte or a signature byte, chosen by the low bits of the load pointer.

In configuration mode, the pointer picks one of four bytes: fuse low, lock, extended fuse or fuse high. In signature mode, the pointer indexes a small signature row. The window closes by itself. It closes when a load consumes it, when it times out, or, in configuration mode only, when a store to program memory arrives. After it closes, loads pass program-memory data through unchanged.

Fuse, lock and signature contents arrive as static input vectors. A bit value of 0 means programmed and 1 means unprogrammed, and the block returns these values as they are. While the nonvolatile storage reports busy, control writes are ignored.

Top module: `cbr_readback`

## Requirements
- R1: A control write (`ctl_wr`=1, `nvm_busy`=0) arms the block when `ctl_wdata` bit 0 (enable) is 1 and bit 1 (configuration select) or bit 2 (signature select) is 1. `ctl_state` then reads 3'b011 for configuration mode or 3'b101 for signature mode, using the same bit positions. If both select bits are written, configuration mode wins.
- R2: A load (`ld_req`=1) in cycle 1, 2 or 3 after the arming write returns the selected special byte on `ld_rdata` in the same cycle, with `ld_special`=1. Cycle 1 is the first cycle after the clock edge that captures the write.
- R3: A load that returns a special byte clears `ctl_state` to 3'b000 from the next cycle on.
- R4: A load in cycle 4 or later returns `pm_rdata` with `ld_special`=0. In signature mode, when no load arrives, `ctl_state` is 3'b000 from cycle 4 on.
- R5: In configuration mode the register stays armed through cycle 4, and a store (`st_req`=1) in cycles 1 to 4 clears it from the next cycle on. With neither a load hit nor a store, it reads 3'b000 from cycle 5. A store in signature mode has no effect.
- R6: In configuration mode, `ld_addr[1:0]` selects the byte: 0 returns fuse low, 1 returns lock, 2 returns extended fuse and 3 returns fuse high. Higher address bits are ignored.
- R7: The lock byte is {2'b11, `lock_raw[5:0]`} and the extended-fuse byte is {5'b11111, `fuse_ext[2:0]`}. Input bits pass unchanged, 0 meaning programmed.
- R8: In signature mode, byte i of the row is `sig_row[8i+7:8i]`, and the index is the low $clog2(SIG_BYTES) bits of `ld_addr`. An index of SIG_BYTES or more returns 8'hFF.
- R9: Control writes while `nvm_busy`=1 are ignored. They neither arm nor disarm the block.
- R10: A new arming write restarts the window count from cycle 1 and may switch modes. A control write that does not arm clears `ctl_state` to 3'b000.
- R11: After reset, and whenever the block is not armed, `ctl_state` is 3'b000, `ld_special` is 0 and `ld_rdata` equals `pm_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: bit0 enable, bit1 configuration select, bit2 signature select |
| nvm_busy | input | 1 | Nonvolatile storage busy; blocks control writes |
| ld_req | input | 1 | Program-memory load issued this cycle |
| st_req | input | 1 | Program-memory store issued this cycle |
| ld_addr | input | ADDR_W | Load pointer address |
| pm_rdata | input | 8 | Normal program-memory read data |
| fuse_lo | input | 8 | Fuse low byte contents |
| fuse_hi | input | 8 | Fuse high byte contents |
| fuse_ext | input | 3 | Extended fuse valid bits |
| lock_raw | input | 6 | Lock bits, bit0 upward |
| sig_row | input | SIG_BYTES*8 | Signature row, byte 0 in the low bits |
| ld_rdata | output | 8 | Data returned to the load |
| ld_special | output | 1 | This load returned a special byte |
| ctl_state | output | 3 | Control register contents (same bit layout as ctl_wdata) |

## Verification
The assertions assume that `ctl_wr`, `ld_req` and `st_req` are single-cycle strobes with stable data while high. They also assume the fuse, lock and signature inputs do not change while a window is open. The bench holds these inputs constant for the whole run. It drives each strobe for exactly one cycle, setting it on a falling edge and releasing it on the next. It never issues a load and a control write in the same cycle, so the assertion that a hit clears the window is never masked by a rearm.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int BYTE_W = 8;
    localparam int LOCK_W = 6;
    localparam int EXT_W  = 3;

    // Control register layout: bit0 enable, bit1 config select, bit2 signature select
    typedef struct packed {
        logic sig;
        logic cfg;
        logic en;
    } ctl_t;
endpackage

// File: rtl/cbr_window.sv
module cbr_window
    import cbr_pkg::*;
#(
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  ctl_t wdata,
    input  logic busy,
    input  logic ld_req,
    input  logic st_req,
    output ctl_t ctl,
    output logic load_open
);
    localparam int CNT_W = $clog2(STORE_WIN + 2);
    localparam logic [CNT_W-1:0] LOAD_LIM  = CNT_W'(LOAD_WIN);
    localparam logic [CNT_W-1:0] STORE_LIM = CNT_W'(STORE_WIN);

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] age;
    } win_t;

    win_t             st_d, st_q;
    logic             store_open;
    logic             close_now;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d       = st_q;
        load_open  = st_q.ctl.en && (st_q.age <= LOAD_LIM);
        store_open = st_q.ctl.en && st_q.ctl.cfg && (st_q.age <= STORE_LIM);
        limit      = st_q.ctl.cfg ? STORE_LIM : LOAD_LIM;
        close_now  = (ld_req && load_open) || (st_req && store_open) || (st_q.age >= limit);

        if (st_q.ctl.en) begin
            if (close_now) begin
                st_d = '0;
            end else begin
                st_d.age = st_q.age + 1'b1;
            end
        end

        if (wr && !busy) begin
            if (wdata.en && (wdata.cfg || wdata.sig)) begin
                st_d.ctl.en  = 1'b1;
                st_d.ctl.cfg = wdata.cfg;
                st_d.ctl.sig = !wdata.cfg;
                st_d.age     = CNT_W'(1);
            end else begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl = st_q.ctl;
endmodule

// File: rtl/cbr_cfg_sel.sv
module cbr_cfg_sel
    import cbr_pkg::*;
(
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] fuse_lo,
    input  logic [BYTE_W-1:0] fuse_hi,
    input  logic [EXT_W-1:0]  fuse_ext,
    input  logic [LOCK_W-1:0] lock_raw,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lock_byte;
    logic [BYTE_W-1:0] ext_byte;

    always_comb begin
        lock_byte = {{(BYTE_W-LOCK_W){1'b1}}, lock_raw};
        ext_byte  = {{(BYTE_W-EXT_W){1'b1}}, fuse_ext};
        case (sel)
            2'd0:    byte_o = fuse_lo;
            2'd1:    byte_o = lock_byte;
            2'd2:    byte_o = ext_byte;
            default: byte_o = fuse_hi;
        endcase
    end
endmodule

// File: rtl/cbr_sig_sel.sv
module cbr_sig_sel
    import cbr_pkg::*;
#(
    parameter int SIG_BYTES = 3,
    parameter int IDX_W     = 2
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [SIG_BYTES*BYTE_W-1:0] row,
    output logic [BYTE_W-1:0]         byte_o
);
    logic [SIG_BYTES-1:0] hit;
    logic [BYTE_W-1:0]    masked [SIG_BYTES];
    logic [BYTE_W-1:0]    acc;

    for (genvar g = 0; g < SIG_BYTES; g++) begin : g_entry
        assign hit[g]    = (idx == IDX_W'(g));
        assign masked[g] = hit[g] ? row[BYTE_W*g +: BYTE_W] : '0;
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < SIG_BYTES; i++) begin
            acc = acc | masked[i];
        end
        byte_o = (|hit) ? acc : {BYTE_W{1'b1}};
    end
endmodule

// File: rtl/cbr_readback.sv
module cbr_readback
    import cbr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SIG_BYTES = 3,
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_wr,
    input  logic [2:0]                    ctl_wdata,
    input  logic                          nvm_busy,
    input  logic                          ld_req,
    input  logic                          st_req,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [7:0]                    pm_rdata,
    input  logic [7:0]                    fuse_lo,
    input  logic [7:0]                    fuse_hi,
    input  logic [2:0]                    fuse_ext,
    input  logic [5:0]                    lock_raw,
    input  logic [SIG_BYTES*8-1:0]        sig_row,
    output logic [7:0]                    ld_rdata,
    output logic                          ld_special,
    output logic [2:0]                    ctl_state
);
    localparam int IDX_W = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1;

    ctl_t              ctl;
    logic              load_open;
    logic [BYTE_W-1:0] cfg_byte;
    logic [BYTE_W-1:0] sig_byte;
    logic              unused_addr;

    assign unused_addr = ^ld_addr;

    cbr_window #(
        .LOAD_WIN  (LOAD_WIN),
        .STORE_WIN (STORE_WIN)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl_wr),
        .wdata     (ctl_t'(ctl_wdata)),
        .busy      (nvm_busy),
        .ld_req    (ld_req),
        .st_req    (st_req),
        .ctl       (ctl),
        .load_open (load_open)
    );

    cbr_cfg_sel u_cfg (
        .sel      (ld_addr[1:0]),
        .fuse_lo  (fuse_lo),
        .fuse_hi  (fuse_hi),
        .fuse_ext (fuse_ext),
        .lock_raw (lock_raw),
        .byte_o   (cfg_byte)
    );

    cbr_sig_sel #(
        .SIG_BYTES (SIG_BYTES),
        .IDX_W     (IDX_W)
    ) u_sig (
        .idx    (ld_addr[IDX_W-1:0]),
        .row    (sig_row),
        .byte_o (sig_byte)
    );

    always_comb begin
        ld_special = ld_req && load_open;
        if (ld_special) begin
            ld_rdata = ctl.cfg ? cfg_byte : sig_byte;
        end else begin
            ld_rdata = pm_rdata;
        end
    end

    assign ctl_state = ctl;
endmodule

// File: rtl/cbr_readback_chk.sv
module cbr_readback_chk #(
    parameter int LOAD_WIN = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [2:0] ctl_wdata,
    input logic       nvm_busy,
    input logic [1:0] ld_sel,
    input logic       ld_special,
    input logic [7:0] ld_rdata,
    input logic [2:0] ctl_state
);
    logic [3:0] age_q;
    logic       arm_wr;

    assign arm_wr = ctl_wr && !nvm_busy && ctl_wdata[0] && (ctl_wdata[1] || ctl_wdata[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (arm_wr) begin
            age_q <= 4'd1;
        end else if (!ctl_state[0]) begin
            age_q <= '0;
        end else if (age_q != 4'hF) begin
            age_q <= age_q + 4'd1;
        end
    end

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_state[0] |-> (!ld_special && ctl_state == 3'b000));

    // R1
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_state[0] |-> ($countones(ctl_state[2:1]) == 1));

    // R1
    cfg_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !nvm_busy && ctl_wdata == 3'b111) |=> (ctl_state == 3'b011));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && nvm_busy && ctl_state == 3'b000) |=> (ctl_state == 3'b000));

    // R3
    hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_special && !(ctl_wr && !nvm_busy)) |=> (ctl_state == 3'b000));

    // R2
    window_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_special |-> (age_q >= 4'd1 && age_q <= 4'(LOAD_WIN)));

    // R7
    lock_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_special && ctl_state[1] && ld_sel == 2'd1) |-> (ld_rdata[7:6] == 2'b11));
endmodule

bind cbr_readback cbr_readback_chk #(
    .LOAD_WIN (LOAD_WIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .nvm_busy   (nvm_busy),
    .ld_sel     (ld_addr[1:0]),
    .ld_special (ld_special),
    .ld_rdata   (ld_rdata),
    .ctl_state  (ctl_state)
);

// File: tb/sim_cbr_readback.sv
`timescale 1ns/1ps
module sim_cbr_readback;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_wdata = 3'b000;
    logic        nvm_busy = 1'b0;
    logic        ld_req = 1'b0;
    logic        st_req = 1'b0;
    logic [15:0] ld_addr = 16'h0000;
    logic [7:0]  pm_rdata = 8'h3C;
    logic [7:0]  fuse_lo = 8'h5E;
    logic [7:0]  fuse_hi = 8'h99;
    logic [2:0]  fuse_ext = 3'b101;
    logic [5:0]  lock_raw = 6'b101100;
    logic [23:0] sig_row = {8'h82, 8'h96, 8'h1E};
    logic [7:0]  ld_rdata;
    logic        ld_special;
    logic [2:0]  ctl_state;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [7:0] EXP_LOCK = 8'hEC;
    localparam logic [7:0] EXP_EXT  = 8'hFD;

    always #2.5 clk = ~clk;

    cbr_readback u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .nvm_busy   (nvm_busy),
        .ld_req     (ld_req),
        .st_req     (st_req),
        .ld_addr    (ld_addr),
        .pm_rdata   (pm_rdata),
        .fuse_lo    (fuse_lo),
        .fuse_hi    (fuse_hi),
        .fuse_ext   (fuse_ext),
        .lock_raw   (lock_raw),
        .sig_row    (sig_row),
        .ld_rdata   (ld_rdata),
        .ld_special (ld_special),
        .ctl_state  (ctl_state)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one-cycle control write; returns in cycle 1 after the capturing edge
    task automatic do_write(input logic [2:0] w);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_wr = 1'b0;
        ctl_wdata = 3'b000;
    endtask

    task automatic t_reset;
        #1 chk("R11 reset state", {5'd0, ctl_state}, 8'h00);
        ld_req = 1'b1; ld_addr = 16'h0001;
        #1 chk("R11 idle load data", ld_rdata, 8'h3C);
        chk("R11 idle special", {7'd0, ld_special}, 8'h00);
        @(negedge clk); ld_req = 1'b0;
    endtask

    task automatic t_cfg_hit(input int k);
        do_write(3'b011);
        repeat (k-1) @(negedge clk);
        ld_req = 1'b1; ld_addr = 16'h0001;
        #1 chk($sformatf("R2 cfg hit cycle %0d", k), ld_rdata, EXP_LOCK);
        chk("R2 special flag", {7'd0, ld_special}, 8'h01);
        @(negedge clk); ld_req = 1'b0;
        #1 chk("R3 cleared after hit", {5'd0, ctl_state}, 8'h00);
    endtask

    task automatic t_cfg_miss4;
        do_write(3'b011);
        repeat (3) @(negedge clk);
        #1 chk("R5 cfg armed in cycle 4", {5'd0, ctl_state}, 8'h03);
        ld_req = 1'b1; ld_addr = 16'h0000;
        #1 chk("R4 cycle 4 load data", ld_rdata, 8'h3C);
        chk("R4 cycle 4 special", {7'd0, ld_special}, 8'h00);
        @(negedge clk); ld_req = 1'b0;
        #1 chk("R5 cfg cleared cycle 5", {5'd0, ctl_state}, 8'h00);
    endtask

    task automatic t_map;
        logic [7:0] exp_b [4];
        exp_b[0] = 8'h5E; exp_b[1] = EXP_LOCK; exp_b[2] = EXP_EXT; exp_b[3] = 8'h99;
        for (int a = 0; a < 4; a++) begin
            do_write(3'b011);
            ld_req = 1'b1; ld_addr = 16'hA5F0 | 16'(a);
            #1 chk($sformatf("R6 R7 cfg addr %0d", a), ld_rdata, exp_b[a]);
            @(negedge clk); ld_req = 1'b0;
        end
    endtask

    task automatic t_sig;
        logic [7:0] exp_b [4];
        exp_b[0] = 8'h1E; exp_b[1] = 8'h96; exp_b[2] = 8'h82; exp_b[3] = 8'hFF;
        for (int i = 0; i < 4; i++) begin
            do_write(3'b101);
            @(negedge clk);
            ld_req = 1'b1; ld_addr = 16'(i);
            #1 chk($sformatf("R8 sig index %0d", i), ld_rdata, exp_b[i]);
            chk("R8 sig special", {7'd0, ld_special}, 8'h01);
            @(negedge clk); ld_req = 1'b0;
            #1 chk("R3 sig cleared after hit", {5'd0, ctl_state}, 8'h00);
        end
        do_write(3'b101);
        repeat (3) @(negedge clk);
        #1 chk("R4 sig cleared cycle 4", {5'd0, ctl_state}, 8'h00);
        ld_req = 1'b1; ld_addr = 16'h0000;
        #1 chk("R4 sig cycle 4 load data", ld_rdata, 8'h3C);
        @(negedge clk); ld_req = 1'b0;
    endtask

    task automatic t_timeout;
        do_write(3'b011);
        for (int c = 1; c <= 4; c++) begin
            #1 chk($sformatf("R5 cfg armed cycle %0d", c), {5'd0, ctl_state}, 8'h03);
            @(negedge clk);
        end
        #1 chk("R5 cfg timeout", {5'd0, ctl_state}, 8'h00);
        do_write(3'b101);
        for (int c = 1; c <= 3; c++) begin
            #1 chk($sformatf("R1 sig armed cycle %0d", c), {5'd0, ctl_state}, 8'h05);
            @(negedge clk);
        end
        #1 chk("R4 sig timeout", {5'd0, ctl_state}, 8'h00);
    endtask

    task automatic t_store;
        do_write(3'b011);
        @(negedge clk);
        st_req = 1'b1;
        @(negedge clk); st_req = 1'b0;
        #1 chk("R5 cfg store clears", {5'd0, ctl_state}, 8'h00);
        do_write(3'b101);
        st_req = 1'b1;
        @(negedge clk); st_req = 1'b0;
        #1 chk("R5 sig store ignored", {5'd0, ctl_state}, 8'h05);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_busy;
        nvm_busy = 1'b1;
        do_write(3'b011);
        #1 chk("R9 busy write does not arm", {5'd0, ctl_state}, 8'h00);
        nvm_busy = 1'b0;
        do_write(3'b011);
        nvm_busy = 1'b1;
        do_write(3'b000);
        nvm_busy = 1'b0;
        #1 chk("R9 busy write does not disarm", {5'd0, ctl_state}, 8'h03);
        ld_req = 1'b1; ld_addr = 16'h0003;
        #1 chk("R9 window still usable", ld_rdata, 8'h99);
        @(negedge clk); ld_req = 1'b0;
    endtask

    task automatic t_both;
        do_write(3'b111);
        #1 chk("R1 both selects give cfg", {5'd0, ctl_state}, 8'h03);
        ld_req = 1'b1; ld_addr = 16'h0002;
        #1 chk("R1 cfg read after both", ld_rdata, EXP_EXT);
        @(negedge clk); ld_req = 1'b0;
    endtask

    task automatic t_rearm;
        do_write(3'b011);
        @(negedge clk);
        do_write(3'b101);
        repeat (2) @(negedge clk);
        #1 chk("R10 rearm to sig", {5'd0, ctl_state}, 8'h05);
        ld_req = 1'b1; ld_addr = 16'h0000;
        #1 chk("R10 hit in restarted cycle 3", ld_rdata, 8'h1E);
        @(negedge clk); ld_req = 1'b0;
        do_write(3'b011);
        do_write(3'b001);
        #1 chk("R10 non-arming write clears", {5'd0, ctl_state}, 8'h00);
        ld_req = 1'b1; ld_addr = 16'h0001;
        #1 chk("R11 load after clear", ld_rdata, 8'h3C);
        @(negedge clk); ld_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_hit(1);
        t_cfg_hit(2);
        t_cfg_hit(3);
        t_cfg_miss4();
        t_map();
        t_sig();
        t_timeout();
        t_store();
        t_busy();
        t_both();
        t_rearm();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule